// File: doc/BRIEF.md
# Directory Coherence Cache-Line Controller

This block is the cache side of a directory-based coherence scheme for a multiprocessor with distributed shared memory and no shared broadcast medium. It holds a direct-mapped array of single-word lines, each Invalid, Shared or Exclusive. It serves one processor port. On a miss or a write upgrade it sends a point-to-point request to the home node of the address. The home node is taken from the top address bits. The controller then stalls the processor until the matching data reply comes back.

Coherence traffic from home nodes arrives on a separate inbound port. An invalidate drops a shared copy without any answer. A fetch makes the owner return its dirty word and keep a shared copy. A fetch-with-invalidate does the same and then discards the line. When a miss evicts an Exclusive line of another address, the dirty word is written home before the new request goes out. Both message ports use valid/ready handshakes. Inbound coherence messages are still serviced while a miss is outstanding.

Top module: `dir_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `out_valid` and `cpu_done` are low, and `cpu_ready` and `in_ready` are high. A line state never takes the unused fourth encoding.
- R2: A read to a line that is Shared or Exclusive with a matching tag raises `cpu_done` in the cycle after acceptance, with the stored word on `cpu_rdata`, and sends no message.
- R3: A read miss sends message type 0 carrying `out_src` = node ID, `out_dst` = top ID_W address bits and the address. A later type-5 reply for that address completes the access one cycle after it is taken, returns the reply data and leaves the line Shared.
- R4: A write to an Invalid line, a Shared line or a line with another tag sends message type 1. The reply leaves the line Exclusive and holding the written word. A write to a matching Exclusive line updates it in place, completes in the next cycle and sends nothing.
- R5: An invalidate (type 2) for a matching Shared line makes it Invalid and sends no message.
- R6: A fetch (type 3) for a matching Exclusive line sends a data write-back (type 6) with the line's address and word, and leaves the line Shared.
- R7: A fetch-with-invalidate (type 4) for a matching Exclusive line sends a type-6 write-back and leaves the line Invalid.
- R8: A miss whose line is Exclusive under another tag first sends a type-6 write-back of that victim. Only then does it send the type-0 or type-1 request for the new address.
- R9: From acceptance of a missing access until its reply, `cpu_ready` stays low. Inbound invalidates and fetches for other lines are serviced in that time.
- R10: While `out_valid` is high and `out_ready` is low, the outbound message fields do not change.
- R11: An invalidate for a line that is not a matching Shared line, and a fetch of either kind for a line that is not a matching Exclusive line, change nothing and send nothing. A reply that no outstanding miss is waiting for also changes nothing and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | AW | Word address of the access |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Controller can accept an access |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| out_valid | output | 1 | Outbound message present |
| out_ready | input | 1 | Network takes the outbound message |
| out_type | output | 3 | Outbound message type |
| out_src | output | ID_W | Sending node ID |
| out_dst | output | ID_W | Home node ID |
| out_addr | output | AW | Message address |
| out_data | output | DW | Message data word |
| in_valid | input | 1 | Inbound message present |
| in_ready | output | 1 | Controller takes the inbound message |
| in_type | input | 3 | Inbound message type |
| in_addr | input | AW | Inbound message address |
| in_data | input | DW | Inbound message data |

## Verification
On every cycle, the assertions check several properties. Outbound fields hold steady under back-pressure, and line states stay legal. An answered fetch produces a write-back of the fetched address on the next cycle, while an invalidate is never answered. A victim write-back is always followed by a miss request, and a matching reply or an Exclusive write hit completes the access. Only the bench scenarios show the state a line is left in, because that state becomes visible later. Examples are a read hitting after a fetch, a read missing after a fetch-with-invalidate, and mismatched messages leaving lines untouched. The same holds for servicing foreign-line traffic while the processor waits.

// File: rtl/dir_line_ctrl.sv
module dir_line_ctrl #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16,
  parameter int unsigned ID_W = 2,
  parameter int unsigned IDX_W = 3,
  parameter logic [ID_W-1:0] NODE_ID = 2'd1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_ready,
  output logic            cpu_done,
  output logic [DW-1:0]   cpu_rdata,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2:0]      out_type,
  output logic [ID_W-1:0] out_src,
  output logic [ID_W-1:0] out_dst,
  output logic [AW-1:0]   out_addr,
  output logic [DW-1:0]   out_data,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_type,
  input  logic [AW-1:0]   in_addr,
  input  logic [DW-1:0]   in_data
);
  localparam int unsigned NL = 1 << IDX_W;
  localparam int unsigned TW = AW - IDX_W;

  localparam logic [2:0] M_RDMISS = 3'd0;
  localparam logic [2:0] M_WRMISS = 3'd1;
  localparam logic [2:0] M_INV    = 3'd2;
  localparam logic [2:0] M_FETCH  = 3'd3;
  localparam logic [2:0] M_FINV   = 3'd4;
  localparam logic [2:0] M_REPLY  = 3'd5;
  localparam logic [2:0] M_WB     = 3'd6;

  localparam logic [1:0] L_I = 2'd0;
  localparam logic [1:0] L_S = 2'd1;
  localparam logic [1:0] L_E = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_VWB, S_SEND, S_WAIT, S_FWB} st_t;

  st_t st, ret;
  logic [1:0]    lst  [NL];
  logic [TW-1:0] ltag [NL];
  logic [DW-1:0] ldat [NL];

  logic          pend_we;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_wdata;
  logic [2:0]    ob_type;
  logic [AW-1:0] ob_addr;
  logic [DW-1:0] ob_data;
  logic          done_q;
  logic [DW-1:0] rdata_q;

  logic [IDX_W-1:0] c_idx, i_idx, p_idx;
  logic [TW-1:0]    c_tag, i_tag;
  logic             c_hit, c_victim, i_match, take_in;

  function automatic logic [ID_W-1:0] home_of(input logic [AW-1:0] a);
    return a[AW-1 -: ID_W];
  endfunction

  assign c_idx    = cpu_addr[IDX_W-1:0];
  assign c_tag    = cpu_addr[AW-1:IDX_W];
  assign i_idx    = in_addr[IDX_W-1:0];
  assign i_tag    = in_addr[AW-1:IDX_W];
  assign p_idx    = pend_addr[IDX_W-1:0];
  assign c_hit    = (lst[c_idx] != L_I) && (ltag[c_idx] == c_tag);
  assign c_victim = (lst[c_idx] == L_E) && (ltag[c_idx] != c_tag);
  assign i_match  = (lst[i_idx] != L_I) && (ltag[i_idx] == i_tag);

  assign cpu_ready = (st == S_IDLE) && !in_valid;
  assign in_ready  = (st == S_IDLE) || (st == S_WAIT);
  assign take_in   = in_valid && in_ready;
  assign out_valid = (st == S_VWB) || (st == S_SEND) || (st == S_FWB);
  assign out_type  = ob_type;
  assign out_src   = NODE_ID;
  assign out_dst   = home_of(ob_addr);
  assign out_addr  = ob_addr;
  assign out_data  = ob_data;
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ret <= S_IDLE;
      for (int k = 0; k < NL; k++) begin
        lst[k]  <= L_I;
        ltag[k] <= '0;
        ldat[k] <= '0;
      end
      pend_we <= 1'b0;
      pend_addr <= '0;
      pend_wdata <= '0;
      ob_type <= M_RDMISS;
      ob_addr <= '0;
      ob_data <= '0;
      done_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (take_in) begin
        case (in_type)
          M_INV:
            if (i_match && lst[i_idx] == L_S) lst[i_idx] <= L_I;
          M_FETCH, M_FINV:
            if (i_match && lst[i_idx] == L_E) begin
              lst[i_idx] <= (in_type == M_FETCH) ? L_S : L_I;
              ob_type <= M_WB;
              ob_addr <= in_addr;
              ob_data <= ldat[i_idx];
              ret <= st;
              st <= S_FWB;
            end
          M_REPLY:
            if (st == S_WAIT && in_addr == pend_addr) begin
              lst[p_idx]  <= pend_we ? L_E : L_S;
              ltag[p_idx] <= pend_addr[AW-1:IDX_W];
              ldat[p_idx] <= pend_we ? pend_wdata : in_data;
              rdata_q <= in_data;
              done_q <= 1'b1;
              st <= S_IDLE;
            end
          default: ;
        endcase
      end else begin
        case (st)
          S_IDLE:
            if (cpu_valid) begin
              if (c_hit && !cpu_we) begin
                rdata_q <= ldat[c_idx];
                done_q <= 1'b1;
              end else if (c_hit && lst[c_idx] == L_E) begin
                ldat[c_idx] <= cpu_wdata;
                done_q <= 1'b1;
              end else begin
                pend_we <= cpu_we;
                pend_addr <= cpu_addr;
                pend_wdata <= cpu_wdata;
                if (c_victim) begin
                  ob_type <= M_WB;
                  ob_addr <= {ltag[c_idx], c_idx};
                  ob_data <= ldat[c_idx];
                  lst[c_idx] <= L_I;
                  st <= S_VWB;
                end else begin
                  ob_type <= cpu_we ? M_WRMISS : M_RDMISS;
                  ob_addr <= cpu_addr;
                  ob_data <= '0;
                  st <= S_SEND;
                end
              end
            end
          S_VWB:
            if (out_ready) begin
              ob_type <= pend_we ? M_WRMISS : M_RDMISS;
              ob_addr <= pend_addr;
              ob_data <= '0;
              st <= S_SEND;
            end
          S_SEND: if (out_ready) st <= S_WAIT;
          S_FWB:  if (out_ready) st <= ret;
          default: ;
        endcase
      end
    end
  end

  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_addr)
                                && $stable(out_data) && $stable(out_dst));

  a_r3_reply_completes: assert property (@(posedge clk) disable iff (!rst_n)
    take_in && in_type == M_REPLY && st == S_WAIT && in_addr == pend_addr |=> cpu_done);

  a_r6_fetch_answered: assert property (@(posedge clk) disable iff (!rst_n)
    take_in && (in_type == M_FETCH || in_type == M_FINV) && i_match && lst[i_idx] == L_E
    |=> out_valid && out_type == M_WB && out_addr == $past(in_addr));

  a_r5_inv_silent: assert property (@(posedge clk) disable iff (!rst_n)
    take_in && in_type == M_INV |=> !out_valid);

  a_r8_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_VWB && out_ready |=> out_valid && (out_type == M_RDMISS || out_type == M_WRMISS));

  a_r4_write_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready && cpu_we && c_hit && lst[c_idx] == L_E |=> cpu_done && !out_valid);

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cpu_ready && !cpu_done);

  for (genvar g = 0; g < NL; g++) begin : g_line_chk
    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n) lst[g] != 2'b11);
  end
endmodule

// File: tb/dir_line_ctrl_test.sv
`timescale 1ns/1ps
module dir_line_ctrl_test;
  localparam int AW = 12, DW = 16, ID_W = 2, IDX_W = 3;
  localparam int NL = 1 << IDX_W, TW = AW - IDX_W;
  localparam logic [ID_W-1:0] NID = 2'd1;
  localparam logic [2:0] M_RDMISS = 0, M_WRMISS = 1, M_INV = 2, M_FETCH = 3,
                         M_FINV = 4, M_REPLY = 5, M_WB = 6;
  localparam logic [1:0] L_I = 0, L_S = 1, L_E = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_we = 0, cpu_ready, cpu_done;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic out_valid, out_ready = 0;
  logic [2:0] out_type;
  logic [ID_W-1:0] out_src, out_dst;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic in_valid = 0, in_ready;
  logic [2:0] in_type = '0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;

  always #2 clk = ~clk;

  dir_line_ctrl #(.AW(AW), .DW(DW), .ID_W(ID_W), .IDX_W(IDX_W), .NODE_ID(NID)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_src(out_src),
    .out_dst(out_dst), .out_addr(out_addr), .out_data(out_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_type(in_type), .in_addr(in_addr), .in_data(in_data));

  logic [1:0]    m_st  [NL];
  logic [TW-1:0] m_tag [NL];
  logic [DW-1:0] m_dat [NL];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return DW'((a * 37) ^ 16'h5a5a);
  endfunction

  function automatic logic [ID_W-1:0] home(input logic [AW-1:0] a);
    return a[AW-1 -: ID_W];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic take_msg(input logic [2:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit chk_data, input string req);
    int w;
    logic [2:0] ct;
    logic [AW-1:0] ca;
    logic [DW-1:0] cd;
    w = 0;
    while (!out_valid && w < 50) begin tick(); w++; end
    chk(out_valid, req, 32'(out_valid), 1);
    ct = out_type; ca = out_addr; cd = out_data;
    repeat ($urandom_range(0, 2)) begin
      tick();
      chk(out_valid && out_type == ct && out_addr == ca && out_data == cd, "R10",
          {13'b0, out_type, out_addr}, {13'b0, ct, ca});
    end
    chk(out_type == t, req, 32'(out_type), 32'(t));
    chk(out_addr == a, req, 32'(out_addr), 32'(a));
    chk(out_dst == home(a) && out_src == NID, req, {out_dst, out_src}, {home(a), NID});
    if (chk_data) chk(out_data == d, req, 32'(out_data), 32'(d));
    out_ready = 1;
    tick();
    out_ready = 0;
  endtask

  task automatic send_in(input logic [2:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w;
    in_valid = 1; in_type = t; in_addr = a; in_data = d;
    w = 0;
    while (!in_ready && w < 50) begin tick(); w++; end
    tick();
    in_valid = 0;
  endtask

  task automatic inbound(input logic [2:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [IDX_W-1:0] ix;
    bit match;
    ix = a[IDX_W-1:0];
    match = m_st[ix] != L_I && m_tag[ix] == a[AW-1:IDX_W];
    send_in(t, a, d);
    chk(!cpu_done, "R11", 32'(cpu_done), 0);
    if ((t == M_FETCH || t == M_FINV) && match && m_st[ix] == L_E) begin
      take_msg(M_WB, a, m_dat[ix], 1, t == M_FETCH ? "R6" : "R7");
      m_st[ix] = (t == M_FETCH) ? L_S : L_I;
    end else begin
      chk(!out_valid, t == M_INV ? "R5" : "R11", 32'(out_valid), 0);
      if (t == M_INV && match && m_st[ix] == L_S) m_st[ix] = L_I;
    end
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input bit inject);
    logic [IDX_W-1:0] ix, oix;
    logic [TW-1:0] tg;
    logic [AW-1:0] oa;
    bit hit;
    int w;
    ix = a[IDX_W-1:0];
    tg = a[AW-1:IDX_W];
    hit = m_st[ix] != L_I && m_tag[ix] == tg;
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    w = 0;
    while (!cpu_ready && w < 50) begin tick(); w++; end
    tick();
    cpu_valid = 0;
    if (hit && (!we || m_st[ix] == L_E)) begin
      chk(cpu_done, we ? "R4" : "R2", 32'(cpu_done), 1);
      chk(!out_valid, we ? "R4" : "R2", 32'(out_valid), 0);
      if (!we) chk(cpu_rdata == m_dat[ix], "R2", 32'(cpu_rdata), 32'(m_dat[ix]));
      else m_dat[ix] = wd;
    end else begin
      if (m_st[ix] == L_E && m_tag[ix] != tg) begin
        take_msg(M_WB, {m_tag[ix], ix}, m_dat[ix], 1, "R8");
        m_st[ix] = L_I;
      end
      take_msg(we ? M_WRMISS : M_RDMISS, a, '0, 0, we ? "R4" : "R3");
      chk(!cpu_ready && !cpu_done, "R9", {cpu_ready, cpu_done}, 0);
      if (inject) begin
        oix = ix + IDX_W'($urandom_range(1, NL - 1));
        oa = {($urandom_range(0, 1) == 1) ? m_tag[oix] : TW'($urandom_range(0, 5) * 83), oix};
        inbound(3'($urandom_range(2, 4)), oa, '0);
        chk(!cpu_ready, "R9", 32'(cpu_ready), 0);
      end
      send_in(M_REPLY, a, mem_val(a));
      chk(cpu_done, we ? "R4" : "R3", 32'(cpu_done), 1);
      if (!we) chk(cpu_rdata == mem_val(a), "R3", 32'(cpu_rdata), 32'(mem_val(a)));
      m_tag[ix] = tg;
      m_st[ix] = we ? L_E : L_S;
      m_dat[ix] = we ? wd : mem_val(a);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1-R11 run actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    for (int k = 0; k < NL; k++) begin m_st[k] = L_I; m_tag[k] = '0; m_dat[k] = '0; end
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(!out_valid && !cpu_done, "R1", {out_valid, cpu_done}, 0);
    chk(cpu_ready && in_ready, "R1", {cpu_ready, in_ready}, 2'b11);

    cpu_op(0, 12'h040, '0, 0);       // R3 miss, then R2 hit
    cpu_op(0, 12'h040, '0, 0);
    cpu_op(1, 12'h040, 16'h1234, 0); // R4 upgrade from Shared
    cpu_op(1, 12'h040, 16'hbeef, 0); // R4 hit in Exclusive
    cpu_op(0, 12'h040, '0, 0);
    inbound(M_FETCH, 12'h040, '0);   // R6
    cpu_op(0, 12'h040, '0, 0);
    inbound(M_INV, 12'h040, '0);     // R5
    cpu_op(0, 12'h040, '0, 0);
    cpu_op(1, 12'h041, 16'h0f0f, 0);
    inbound(M_FINV, 12'h041, '0);    // R7
    cpu_op(0, 12'h041, '0, 0);
    cpu_op(1, 12'h042, 16'h7777, 0);
    cpu_op(0, 12'hC02, '0, 0);       // R8 victim write-back first
    cpu_op(1, 12'h803, 16'h5555, 0);
    inbound(M_INV, 12'h803, '0);     // R11 invalidate on Exclusive ignored
    inbound(M_FETCH, 12'hC02, '0);   // R11 fetch on Shared ignored
    inbound(M_FETCH, 12'h003, '0);   // R11 tag mismatch
    inbound(M_REPLY, 12'h803, 16'h1111); // R11 stray reply
    cpu_op(0, 12'h803, '0, 0);
    cpu_op(1, 12'h444, 16'h2468, 0);
    cpu_op(0, 12'h105, '0, 1);       // R9 service while waiting

    for (int i = 0; i < 500; i++) begin
      logic [AW-1:0] a;
      a = {TW'($urandom_range(0, 5) * 83), IDX_W'($urandom_range(0, NL - 1))};
      if ($urandom_range(0, 3) == 0) inbound(3'($urandom_range(2, 5)), a, 16'(i));
      else cpu_op($urandom_range(0, 1) == 1, a, 16'($urandom), $urandom_range(0, 2) == 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule